// File: doc/BRIEF.md
# Timer Pin Port with Atomic Set and Clear

This block is the 32-pin input/output port of a programmable timer. A simple register interface lets software program a per-pin direction, write the output data word directly, read back the captured input levels, and change chosen output bits through separate write-one-to-set and write-one-to-clear masks. Because no read-modify-write is needed, two pieces of software touching different pins cannot corrupt each other's bits.

The timer's instruction engine can also force individual output bits high or low through a pair of per-pin request vectors. All register and engine updates land in an internal data-out word at once. That word, gated by direction, reaches the pads only on a clock edge where the loop resolution strobe is high. Pad inputs go through a two-stage synchroniser and are latched into the data-in word on the same strobe.

The register read path is combinational on the address. One address is presented per cycle, so at most one bus write happens in a cycle. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `tmr_pin_port`

## Requirements
- R1: After reset every register (direction, data-out, data-in) reads zero, and `pad_o` and `pad_oe` are zero.
- R2: A write to address 1 replaces all 32 data-out bits with the write data. Reading address 1 returns data-out.
- R3: A write to address 3 sets every data-out bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to address 4 clears every data-out bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Engine requests apply in the same edge as any bus write and take priority over it. A bit in `eng_clr` forces data-out low, and wins over the same bit in `eng_set`. A bit in `eng_set` alone forces it high.
- R6: `pad_o` and `pad_oe` change only at a clock edge where `lr_strobe` is high. At that edge they take `data_out & direction` and `direction`, using the values those registers held before the edge.
- R7: Each `pad_i` bit passes through two flops. On a strobe edge the data-in word takes the output of the second flop. Reading address 2 returns data-in.
- R8: Writes to address 2 and to addresses 5 to 7 change nothing. Reads of addresses 3 and 4 return data-out. Reads of addresses 5 to 7 return zero.
- R9: A write to address 0 replaces the direction word, where a 1 bit makes that pin an output. Reading address 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address, also selects read data |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_set | input | 32 | Engine request to drive pins high |
| eng_clr | input | 32 | Engine request to drive pins low |
| lr_strobe | input | 1 | Loop resolution strobe, one clock wide |
| pad_i | input | 32 | Pin levels from the pads |
| pad_o | output | 32 | Registered pin output values |
| pad_oe | output | 32 | Registered pin output enables |

## Verification
The assertions assume that `lr_strobe` and the engine vectors are synchronous to `clk`, and that `bus_addr` is stable through the whole cycle in which `bus_wr` is high. The set and clear properties also assume that no engine request touches the same cycle. The bench drives every input at the falling edge and holds it for the full cycle. It keeps engine requests sparse, so many mask writes arrive with no engine activity and the mask properties are exercised. The random stimulus still mixes in collisions between engine and bus writes, and strobes at about one cycle in four.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int unsigned PIN_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 3'd0,
    RA_DOUT = 3'd1,
    RA_DIN  = 3'd2,
    RA_SET  = 3'd3,
    RA_CLR  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/tpp_regfile.sv
module tpp_regfile
  import tpp_pkg::*;
#(
  parameter int unsigned W = PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      eng_set,
  input  logic [W-1:0]      eng_clr,
  input  logic [W-1:0]      din_word,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir_word,
  output logic [W-1:0]      dout_word
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dout_q, dout_d, bus_dout;
  logic         dir_en, dout_en;
  logic         any_eng;

  assign any_eng = (|eng_set) || (|eng_clr);

  // bus update of data-out, before engine requests
  always_comb begin
    bus_dout = dout_q;
    dir_d    = dir_q;
    if (wr_en) begin
      case (addr)
        RA_DIR:  dir_d    = wdata;
        RA_DOUT: bus_dout = wdata;
        RA_SET:  bus_dout = dout_q | wdata;
        RA_CLR:  bus_dout = dout_q & ~wdata;
        default: ;
      endcase
    end
  end

  // engine merge per bit: clear beats set, both beat the bus
  for (genvar b = 0; b < W; b++) begin : g_merge
    always_comb begin
      if (eng_clr[b])      dout_d[b] = 1'b0;
      else if (eng_set[b]) dout_d[b] = 1'b1;
      else                 dout_d[b] = bus_dout[b];
    end
  end

  assign dir_en  = wr_en && (addr == RA_DIR);
  assign dout_en = any_eng ||
                   (wr_en && (addr == RA_DOUT || addr == RA_SET || addr == RA_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end

  always_comb begin
    case (addr)
      RA_DIR:                  rdata = dir_q;
      RA_DOUT, RA_SET, RA_CLR: rdata = dout_q;
      RA_DIN:                  rdata = din_word;
      default:                 rdata = '0;
    endcase
  end

  assign dir_word  = dir_q;
  assign dout_word = dout_q;

  assert_set_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_SET && !any_eng) |=>
      (((dout_q & $past(wdata)) == $past(wdata)) &&
       ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));

  assert_clr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CLR && !any_eng) |=>
      (((dout_q & $past(wdata)) == '0) &&
       ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));

  assert_eng_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_clr) |=> ((dout_q & $past(eng_clr)) == '0));

  assert_eng_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_set) |=> ((dout_q & ($past(eng_set) & ~$past(eng_clr))) ==
                    ($past(eng_set) & ~$past(eng_clr))));

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == RA_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/tpp_out_stage.sv
module tpp_out_stage
  import tpp_pkg::*;
#(
  parameter int unsigned W = PIN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lr_strobe,
  input  logic [W-1:0] dout_word,
  input  logic [W-1:0] dir_word,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] pin_q, oe_q;
  logic [W-1:0] pin_d, oe_d;

  for (genvar b = 0; b < W; b++) begin : g_pin
    always_comb begin
      pin_d[b] = dout_word[b] & dir_word[b];
      oe_d[b]  = dir_word[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_q[b] <= 1'b0;
        oe_q[b]  <= 1'b0;
      end else if (lr_strobe) begin
        pin_q[b] <= pin_d[b];
        oe_q[b]  <= oe_d[b];
      end
    end
  end

  assign pad_o  = pin_q;
  assign pad_oe = oe_q;

  assert_pads_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_strobe |=> ($stable(pad_o) && $stable(pad_oe)));

  assert_pads_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lr_strobe |=> (pad_oe == $past(dir_word) &&
                   pad_o == ($past(dout_word) & $past(dir_word))));

  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_o & ~pad_oe) == '0));
endmodule

// File: rtl/tpp_in_sampler.sv
module tpp_in_sampler
  import tpp_pkg::*;
#(
  parameter int unsigned W      = PIN_W,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lr_strobe,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] din_word
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] din_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pad_i;
    end else begin : g_next
      assign stage_d = sync_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         din_q <= '0;
    else if (lr_strobe) din_q <= sync_q[LAST];
  end

  assign din_word = din_q;

  assert_din_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_strobe |=> $stable(din_q));

  assert_din_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lr_strobe |=> (din_q == $past(sync_q[LAST])));
endmodule

// File: rtl/tmr_pin_port.sv
module tmr_pin_port
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  eng_set,
  input  logic [PIN_W-1:0]  eng_clr,
  input  logic              lr_strobe,
  input  logic [PIN_W-1:0]  pad_i,
  output logic [PIN_W-1:0]  pad_o,
  output logic [PIN_W-1:0]  pad_oe
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [PIN_W-1:0]      dir_word, dout_word, din_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  tpp_regfile #(.W(PIN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .eng_set   (eng_set),
    .eng_clr   (eng_clr),
    .din_word  (din_word),
    .rdata     (bus_rdata),
    .dir_word  (dir_word),
    .dout_word (dout_word)
  );

  tpp_out_stage #(.W(PIN_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lr_strobe (lr_strobe),
    .dout_word (dout_word),
    .dir_word  (dir_word),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe)
  );

  tpp_in_sampler #(.W(PIN_W), .STAGES(2)) u_in (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lr_strobe (lr_strobe),
    .pad_i     (pad_i),
    .din_word  (din_word)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |=> (pad_o == '0 && pad_oe == '0) || !rst_int_n);
endmodule

// File: tb/tmr_pin_port_tb_top.sv
module tmr_pin_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] eng_set, eng_clr;
  logic        lr_strobe;
  logic [31:0] pad_i, pad_o, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of architectural state
  logic [31:0] m_dir, m_dout, m_din, m_s1, m_s2, m_po, m_oe;

  always #4 clk = ~clk;

  tmr_pin_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_set(eng_set),
    .eng_clr(eng_clr), .lr_strobe(lr_strobe), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:       return m_dir;
      3'd1:       return m_dout;
      3'd2:       return m_din;
      3'd3, 3'd4: return m_dout;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [2:0] a);
    case (a)
      3'd0:    return "R9";
      3'd1:    return "R2";
      3'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] next_dout(logic w, logic [2:0] a,
      logic [31:0] d, logic [31:0] es, logic [31:0] ec);
    logic [31:0] n;
    n = m_dout;
    if (w && a == 3'd1) n = d;
    if (w && a == 3'd3) n = m_dout | d;
    if (w && a == 3'd4) n = m_dout & ~d;
    return (n | es) & ~ec;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dir = '0; m_dout = '0; m_din = '0;
    m_s1 = '0; m_s2 = '0; m_po = '0; m_oe = '0;
  endtask

  // one clock cycle: drive at negedge, check before the edge, update model
  task automatic step(logic w, logic [2:0] a, logic [31:0] d,
      logic [31:0] es, logic [31:0] ec, logic stb, logic [31:0] pin);
    logic [31:0] nd;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    eng_set = es; eng_clr = ec; lr_strobe = stb; pad_i = pin;
    #1;
    chk(read_tag(a), bus_rdata, exp_read(a));
    chk("R6", pad_o, m_po);
    chk("R6", pad_oe, m_oe);
    @(posedge clk);
    nd = next_dout(w, a, d, es, ec);
    if (stb) begin
      m_po = m_dout & m_dir;
      m_oe = m_dir;
      m_din = m_s2;
    end
    m_s2 = m_s1;
    m_s1 = pin;
    if (w && a == 3'd0) m_dir = d;
    m_dout = nd;
  endtask

  task automatic peek(logic [2:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; eng_set = '0; eng_clr = '0;
    lr_strobe = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_set = '0; eng_clr = '0; lr_strobe = 1'b0; pad_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) peek(a[2:0], "R1", 32'h0);
    chk("R1", pad_o, 32'h0);
    chk("R1", pad_oe, 32'h0);

    // R2 direct write, R3 set mask, R4 clear mask
    step(1, 3'd1, 32'hA5A5_0000, 0, 0, 0, 0);
    peek(3'd1, "R2", 32'hA5A5_0000);
    step(1, 3'd3, 32'h0000_00FF, 0, 0, 0, 0);
    peek(3'd1, "R3", 32'hA5A5_00FF);
    step(1, 3'd4, 32'hA000_000F, 0, 0, 0, 0);
    peek(3'd1, "R4", 32'h05A5_00F0);
    // R5 engine beats bus, engine clear beats engine set
    step(1, 3'd3, 32'h0000_0003, 32'h0000_0102, 32'h0000_0003, 0, 0);
    peek(3'd1, "R5", 32'h05A5_01F0);
    // R8 writes to data-in and unmapped are ignored
    step(1, 3'd2, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0, 0);
    peek(3'd2, "R8", 32'h0);
    peek(3'd6, "R8", 32'h0);
    peek(3'd4, "R8", 32'h05A5_01F0);
    // R9 direction, R6 no pad change until strobe
    step(1, 3'd0, 32'hFFFF_0000, 0, 0, 0, 0);
    peek(3'd0, "R9", 32'hFFFF_0000);
    chk("R6", pad_oe, 32'h0);
    step(0, 3'd0, 0, 0, 0, 1, 0);
    peek(3'd0, "R6", 32'hFFFF_0000);
    chk("R6", pad_o, 32'h05A5_0000);
    chk("R6", pad_oe, 32'hFFFF_0000);
    // R7 input path: two sync flops, then strobe latch
    step(0, 3'd2, 0, 0, 0, 0, 32'h1234_5678);
    step(0, 3'd2, 0, 0, 0, 0, 32'h1234_5678);
    step(0, 3'd2, 0, 0, 0, 1, 32'h1234_5678);
    peek(3'd2, "R7", 32'h1234_5678);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [2:0]  a;
      logic [31:0] es, ec;
      rnd = $urandom;
      w  = rnd[0] | rnd[1];
      a  = rnd[4:2];
      es = (rnd[7:5] == 3'd0) ? $urandom : 32'h0;
      ec = (rnd[10:8] == 3'd0) ? $urandom : 32'h0;
      step(w, a, $urandom, es, ec, rnd[12:11] == 2'd0, $urandom);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule